// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer built around an 8-bit up-counter. A 3-bit clock-select field picks one of eight power-of-two prescaler ratios, from 1/32 to 1/4096. When the counter rolls over from 0xFF to 0x00, the block sets a sticky overflow flag and emits a one-clock overflow pulse. Software keeps the watchdog from firing by rewriting the counter before it wraps.

Both writable registers are guarded by a key byte. A write lands only if the upper part of the bus word carries the key that belongs to the addressed register: 0x5A for the counter and 0xA5 for the control/status register. Any other write is dropped silently. A mode input chooses where the key sits. In 16-bit mode it is in bits 15:8. In 32-bit mode it is in bits 31:24. In both modes the payload is always bits 7:0. Reads need no key and return one byte.

Top module: `kwdt_top`

## Requirements
- R1: With `bus32` low, a write to address 0 (counter) loads bits 7:0 into the counter only if bits 15:8 equal 0x5A. Any other key, including 0xA5, leaves the counter unchanged.
- R2: With `bus32` low, a write to address 1 (control/status) is accepted only if bits 15:8 equal 0xA5. The control/status byte has bit 7 = overflow flag, bit 5 = timer enable and bits 2:0 = clock select. All other bits read 0. A rejected write changes nothing.
- R3: With `bus32` high, the key is taken from bits 31:24 and bits 15:8 are ignored. With `bus32` low, bits 31:24 are ignored.
- R4: `rd_data` combinationally returns the counter when `addr` is 0 and the control/status byte when `addr` is 1.
- R5: After a synchronous active-low reset, the counter reads 0x00, the control/status byte reads 0x00 (timer disabled, select 0 = divide by 32) and `ovf_pulse` is low.
- R6: While the timer is enabled, the counter advances once every 32·2^sel clocks. The prescaler restarts on an accepted counter write, on a change of the select field and while the timer is disabled. The first advance therefore comes a full period after any of these events.
- R7: While the timer is disabled, the counter holds its value.
- R8: On a wrap from 0xFF to 0x00, the flag is set and `ovf_pulse` is high for exactly the one cycle in which the counter first reads 0x00.
- R9: The flag is cleared by an accepted control/status write with bit 7 = 0. Writing bit 7 = 1 has no effect. A wrap in the same cycle as a clearing write leaves the flag set.
- R10: An accepted counter write in the same cycle as a prescaler tick wins. The counter takes the written value, no wrap is signalled, and the next advance is a full period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus32 | input | 1 | Key position: 1 = bits 31:24, 0 = bits 15:8 |
| addr | input | 1 | Register select: 0 counter, 1 control/status |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write word: key byte plus payload in bits 7:0 |
| rd_data | output | 8 | Read byte of the selected register |
| ovf_pulse | output | 1 | One-clock pulse on counter wrap |

## Verification
Two pairs of functions can land on the same clock edge. A keyed write to the counter can coincide with the prescaler tick that would wrap it. A flag-clearing control/status write can coincide with a wrap. The bench preloads the counter with 0xFF and counts exactly one division period of edges. It then issues the write so that it lands on the tick edge. It judges the result from the counter value, the pulse and the flag read back in the following cycle: the counter write must win with no pulse, and the overflow must win over the flag clear.

// File: rtl/kwdt_pkg.sv
// Package: shared constants and types of the key-protected watchdog.
// Assumes an 8-bit counter and a 3-bit clock-select field.
package kwdt_pkg;
    localparam int BUS_W    = 32;
    localparam int BYTE_W   = 8;
    localparam int SEL_W    = 3;
    localparam int BASE_LOG = 5;   // smallest division is 2**BASE_LOG
    localparam int FLAG_BIT = 7;
    localparam int RUN_BIT  = 5;
    localparam int NUM_REGS = 2;

    typedef enum logic {
        REG_COUNT = 1'b0,
        REG_CTRL  = 1'b1
    } reg_sel_e;

    // Key byte per register, indexed by reg_sel_e value.
    localparam logic [NUM_REGS-1:0][BYTE_W-1:0] REG_KEYS = {8'hA5, 8'h5A};

    typedef struct packed {
        logic             flag;
        logic             run;
        logic [SEL_W-1:0] sel;
    } ctrl_t;
endpackage

// File: rtl/kwdt_keygate.sv
// Key gate: turns a raw bus write into per-register write enables.
// The key is taken from bits 31:24 or 15:8, depending on bus32.
// Assumes one write per cycle and a payload in bits 7:0.
module kwdt_keygate
    import kwdt_pkg::*;
(
    input  logic              bus32,
    input  logic              addr,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              cnt_we,
    output logic              ctrl_we,
    output logic [BYTE_W-1:0] payload
);
    localparam int KEY_LO16 = BYTE_W;
    localparam int KEY_LO32 = BUS_W - BYTE_W;

    logic [BYTE_W-1:0]   key_field;
    logic [NUM_REGS-1:0] hit;

    // Select the key byte according to the bus mode.
    always_comb begin
        key_field = bus32 ? wr_data[KEY_LO32 +: BYTE_W] : wr_data[KEY_LO16 +: BYTE_W];
    end

    // One comparator per register, each with its own key.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_key
        assign hit[i] = wr_en && (int'(addr) == i) && (key_field == REG_KEYS[i]);
    end

    assign cnt_we  = hit[REG_COUNT];
    assign ctrl_we = hit[REG_CTRL];
    assign payload = wr_data[BYTE_W-1:0];
endmodule

// File: rtl/kwdt_prescaler.sv
// Prescaler: emits a one-cycle tick every 2**(BASE_LOG+sel) clocks while enabled.
// Restarts from zero on clr or while disabled.
module kwdt_prescaler
    import kwdt_pkg::*;
#(
    parameter int P_BASE_LOG = BASE_LOG,
    parameter int P_SEL_W    = SEL_W
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               clr,
    input  logic [P_SEL_W-1:0] sel,
    output logic               tick
);
    localparam int MAX_SEL = (1 << P_SEL_W) - 1;
    localparam int PRE_W   = P_BASE_LOG + MAX_SEL;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    // Terminal count for the selected ratio.
    always_comb begin
        limit = {PRE_W{1'b1}} >> (MAX_SEL - int'(sel));
    end

    assign tick = run && (pre_q == limit);

    // Count clocks; wrap on tick; restart on clear or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run || tick) pre_q <= '0;
        else                               pre_q <= pre_q + 1'b1;
    end

    assert_pre_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= limit);
    assert_restart_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pre_q == '0);
endmodule

// File: rtl/kwdt_counter.sv
// Counter: 8-bit up-counter advanced by prescaler ticks.
// A write has priority over a tick. A wrap is flagged combinationally
// and as a registered one-cycle pulse.
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int P_W = BYTE_W
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           run,
    input  logic           we,
    input  logic [P_W-1:0] wdata,
    output logic [P_W-1:0] count,
    output logic           wrap,
    output logic           pulse
);
    logic [P_W-1:0] cnt_q;
    logic           pulse_q;

    assign wrap = tick && !we && (cnt_q == {P_W{1'b1}});

    // Counter update: write wins, else advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (we)   cnt_q <= wdata;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    // Register the wrap event into a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= wrap;
    end

    assign count = cnt_q;
    assign pulse = pulse_q;

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
    assert_pulse_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> cnt_q == '0);
    assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !we) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/kwdt_ctrl.sv
// Control/status register: sticky overflow flag, run bit and clock select.
// Overflow set wins over a clear in the same cycle.
// Reports a change of the select field so the prescaler can restart.
module kwdt_ctrl
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ovf_set,
    output ctrl_t             ctrl,
    output logic              sel_change
);
    ctrl_t ctrl_q;

    assign sel_change = we && (wdata[SEL_W-1:0] != ctrl_q.sel);

    // Run bit and select field load on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.run <= 1'b0;
            ctrl_q.sel <= '0;
        end else if (we) begin
            ctrl_q.run <= wdata[RUN_BIT];
            ctrl_q.sel <= wdata[SEL_W-1:0];
        end
    end

    // Sticky flag: set by overflow, cleared only by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ctrl_q.flag <= 1'b0;
        else if (ovf_set)               ctrl_q.flag <= 1'b1;
        else if (we && !wdata[FLAG_BIT]) ctrl_q.flag <= 1'b0;
    end

    assign ctrl = ctrl_q;

    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ctrl_q.flag);
    assert_flag_no_self_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_set && !ctrl_q.flag) |=> !ctrl_q.flag);
endmodule

// File: rtl/kwdt_top.sv
// Key-protected watchdog top: key gate, control register, prescaler
// and counter, with a byte-wide read mux.
// Assumes a single-cycle write bus and combinational reads.
module kwdt_top
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus32,
    input  logic              addr,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ovf_pulse
);
    logic              cnt_we, ctrl_we, sel_change, tick, wrap;
    logic [BYTE_W-1:0] payload, count;
    ctrl_t             ctrl;
    logic [BYTE_W-1:0] ctrl_byte;

    kwdt_keygate u_gate (
        .bus32(bus32), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .cnt_we(cnt_we), .ctrl_we(ctrl_we), .payload(payload)
    );

    kwdt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(payload),
        .ovf_set(wrap), .ctrl(ctrl), .sel_change(sel_change)
    );

    kwdt_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run),
        .clr(cnt_we || sel_change), .sel(ctrl.sel), .tick(tick)
    );

    kwdt_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl.run), .we(cnt_we),
        .wdata(payload), .count(count), .wrap(wrap), .pulse(ovf_pulse)
    );

    // Assemble the status byte; unused bits read as zero.
    always_comb begin
        ctrl_byte              = '0;
        ctrl_byte[FLAG_BIT]    = ctrl.flag;
        ctrl_byte[RUN_BIT]     = ctrl.run;
        ctrl_byte[SEL_W-1:0]   = ctrl.sel;
    end

    // Read mux by address.
    always_comb begin
        rd_data = (addr == REG_CTRL) ? ctrl_byte : count;
    end

    assert_reject_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CTRL && !ctrl_we) |=>
            (ctrl.run == $past(ctrl.run)) && (ctrl.sel == $past(ctrl.sel)));
    assert_pulse_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ctrl.flag);
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> !ovf_pulse);
endmodule

// File: tb/kwdt_top_tb_top.sv
// Directed bench for kwdt_top: one task per scenario.
module kwdt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus32 = 1'b0;
    logic        addr = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_data;
    logic        ovf_pulse;
    int          n_chk = 0;
    int          n_bad = 0;

    kwdt_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus32(bus32), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ovf_pulse(ovf_pulse)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a; #1; v = rd_data;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(0, v); check("R5", "count after reset", v, 8'h00);
        rd(1, v); check("R5", "ctrl after reset", v, 8'h00);
        check("R5", "pulse after reset", {7'b0, ovf_pulse}, 8'h00);
    endtask

    task automatic t_keys16();
        logic [7:0] v;
        wr(0, 32'h0000_1234); rd(0, v); check("R1", "bad key count", v, 8'h00);
        wr(0, 32'h0000_A534); rd(0, v); check("R1", "ctrl key on count", v, 8'h00);
        wr(0, 32'h5A00_0034); rd(0, v); check("R3", "top key in 16-bit mode", v, 8'h00);
        wr(0, 32'h0000_5A34); rd(0, v); check("R1", "good key count", v, 8'h34);
        wr(1, 32'h0000_5A27); rd(1, v); check("R2", "count key on ctrl", v, 8'h00);
        wr(1, 32'h0000_A5FF); rd(1, v); check("R2", "ctrl unused bits zero, flag not set", v, 8'h27);
        wr(1, 32'h0000_A500); rd(1, v); check("R4", "ctrl read back", v, 8'h00);
        wait_n(100); rd(0, v); check("R7", "count holds when stopped", v, 8'h34);
    endtask

    task automatic t_div(input int sel);
        logic [7:0] v;
        int div;
        div = 32 << sel;
        wr(1, 32'h0000_A520 | sel);
        wr(0, 32'h0000_5A10);
        wait_n(div - 1); rd(0, v); check("R6", $sformatf("no advance before period sel=%0d", sel), v, 8'h10);
        wait_n(1);       rd(0, v); check("R6", $sformatf("advance at period sel=%0d", sel), v, 8'h11);
        wr(1, 32'h0000_A500);
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        wr(1, 32'h0000_A520);
        wr(0, 32'h0000_5AFF);
        wait_n(31); rd(0, v); check("R8", "count before wrap", v, 8'hFF);
        check("R8", "no pulse before wrap", {7'b0, ovf_pulse}, 8'h00);
        wait_n(1); rd(0, v); check("R8", "count after wrap", v, 8'h00);
        check("R8", "pulse on wrap", {7'b0, ovf_pulse}, 8'h01);
        rd(1, v); check("R8", "flag after wrap", v, 8'hA0);
        wait_n(1); check("R8", "pulse one cycle", {7'b0, ovf_pulse}, 8'h00);
        wr(1, 32'h0000_A5A0); rd(1, v); check("R9", "write 1 keeps flag", v, 8'hA0);
        wr(1, 32'h0000_A520); rd(1, v); check("R9", "write 0 clears flag", v, 8'h20);
        wr(1, 32'h0000_A500);
    endtask

    task automatic t_bus32();
        logic [7:0] v;
        bus32 = 1'b1;
        wr(0, 32'h0000_5A66); rd(0, v); check("R3", "low key ignored in 32-bit", v, 8'h00);
        wr(0, 32'h5A00_0077); rd(0, v); check("R3", "top key count", v, 8'h77);
        wr(1, 32'h0000_A521); rd(1, v); check("R3", "low key ctrl ignored", v, 8'h00);
        wr(1, 32'hA500_0003); rd(1, v); check("R3", "top key ctrl", v, 8'h03);
        wr(1, 32'hA500_0000);
        bus32 = 1'b0;
    endtask

    task automatic t_collide_flag();
        logic [7:0] v;
        wr(1, 32'h0000_A520);
        wr(0, 32'h0000_5AFF);
        wait_n(31);
        wr(1, 32'h0000_A520);   // lands on the wrap edge
        check("R9", "pulse with clearing write", {7'b0, ovf_pulse}, 8'h01);
        rd(1, v); check("R9", "overflow beats clear", v, 8'hA0);
        wr(1, 32'h0000_A520); rd(1, v); check("R9", "later clear works", v, 8'h20);
    endtask

    task automatic t_collide_count();
        logic [7:0] v;
        wr(0, 32'h0000_5AFF);
        wait_n(31);
        wr(0, 32'h0000_5A40);   // lands on the tick edge
        rd(0, v); check("R10", "write beats tick", v, 8'h40);
        check("R10", "no pulse on overridden wrap", {7'b0, ovf_pulse}, 8'h00);
        rd(1, v); check("R10", "flag stays clear", v, 8'h20);
        wait_n(31); rd(0, v); check("R10", "full period after write", v, 8'h40);
        wait_n(1);  rd(0, v); check("R10", "advance after full period", v, 8'h41);
        wr(1, 32'h0000_A500);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_keys16();
        t_div(0);
        t_div(3);
        t_div(7);
        t_overflow();
        t_bus32();
        t_collide_flag();
        t_collide_count();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule